// File: doc/BRIEF.md
# I2C Slave Address Match Unit

This block listens to a two-wire I2C-compatible bus and decides, once per address phase, whether the local slave is the target. It detects START and STOP conditions from SCL and SDA samples that have already been synchronised. After each START or repeated START it shifts in eight bits, MSB first: seven address bits followed by the R/W bit. It then compares the address with a primary own-address input and with a second register. That second register is either an alternate exact address or a don't-care bit mask. The comparison also covers general-call address zero, the 10-bit addressing prefix, and a match-everything mode that leaves the decision to software.

When the address matches, the block raises a one-cycle match pulse and exposes the received address, the R/W bit and the flags. It requests an ACK (SDA held low) through the ninth clock and holds a wake request until the bus sees the next START or STOP. When the address does not match, the block stays silent and ignores the bus until the next START. Data bytes after the address, clock stretching and master operation are handled elsewhere.

The controller has six states. IDLE waits for START. SHIFT collects bits on rising SCL. DECIDE lasts one clock after the eighth bit. ACK spans the ninth SCL clock. PASS is the matched transfer. SKIP is the unmatched transfer.

The transitions are as follows. Any state goes to SHIFT on START, with the bit count cleared. Any state goes to IDLE on STOP. IDLE goes to SHIFT on START. SHIFT goes to DECIDE on the eighth rising SCL edge. DECIDE goes to ACK on a hit and to SKIP otherwise. ACK goes to PASS on the second falling SCL edge seen in ACK. PASS and SKIP leave only on START or STOP.

Top module: `i2c_addr_match`

## Requirements
- R1: While reset is held and directly after it, match_o, ack_o and wake_o are 0, addr_o is 0 and rw_o is 0.
- R2: An address byte whose upper seven bits equal own_addr_i is a hit. On a hit, addr_o carries those seven bits and rw_o carries bit 0 of the byte (1 = read).
- R3: A byte that is not a hit gives no match, no ACK and no wake. Every later byte is ignored until the next START, and so is every data byte after a matched address.
- R4: With alt_is_mask_i = 0, an address equal to alt_addr_i is also a hit.
- R5: With alt_is_mask_i = 1, each bit set in alt_addr_i is a don't-care in the comparison against own_addr_i. Address a is a hit when (a | alt) == (own | alt).
- R6: With gc_en_i = 1, address 0 is a hit and gc_o = 1. With gc_en_i = 0, address 0 is a hit only through another rule, and gc_o = 0.
- R7: With match_all_i = 1, every address byte is a hit.
- R8: An address whose upper five bits are 11110 (addresses 0x78 to 0x7B) is a hit with tenbit_o = 1. For every other address, tenbit_o = 0.
- R9: match_o is high for exactly one clock. That clock is the first one after the clock edge at which the eighth rising SCL sample was taken.
- R10: After a hit, ack_o is high from the cycle after the match pulse until the clock edge that samples the second falling SCL edge after the match. After that it is 0.
- R11: wake_o rises together with ack_o after a hit. It stays high through the matched transfer and falls one clock after a START or STOP is sampled.
- R12: A START in the middle of an address byte restarts the capture from bit one. A STOP in the middle of an address byte abandons it, and no bits count until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA sample |
| own_addr_i | input | 7 | Primary slave address |
| alt_addr_i | input | 7 | Alternate address, or don't-care mask |
| alt_is_mask_i | input | 1 | 1: alt_addr_i is a mask; 0: it is a second address |
| gc_en_i | input | 1 | Enable general-call recognition |
| match_all_i | input | 1 | Report every address byte as a hit |
| match_o | output | 1 | One-cycle address hit pulse |
| addr_o | output | 7 | Last captured address |
| rw_o | output | 1 | Last captured R/W bit |
| gc_o | output | 1 | Last address was a general call |
| tenbit_o | output | 1 | Last address was a 10-bit prefix |
| ack_o | output | 1 | Request to hold SDA low (ACK) |
| wake_o | output | 1 | Wake request while addressed |

## Verification
Bus edges are driven on falling clock edges, and outputs are sampled on falling edges. The match pulse is therefore checked at the first falling clock edge after the eighth SCL rise is driven. A monitor counts every cycle the pulse is high, which confirms its width of one. ACK is checked in the middle of the ninth SCL high phase, and its release is checked one clock after the ninth SCL fall. The wake request is checked at the end of the byte and again after STOP, by which point the one-cycle delay from the detected condition has passed.

// File: rtl/i2cam_pkg.sv
package i2cam_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_DECIDE,
        ST_ACK,
        ST_PASS,
        ST_SKIP
    } am_state_e;
endpackage

// File: rtl/i2cam_line_watch.sv
module i2cam_line_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // SCL held high across two samples qualifies an SDA change as a condition
    assign scl_rise_o = scl_i & ~scl_q;
    assign scl_fall_o = ~scl_i & scl_q;
    assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2cam_compare.sv
module i2cam_compare #(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] own_i,
    input  logic [ADDR_W-1:0] alt_i,
    input  logic              alt_is_mask_i,
    input  logic              gc_en_i,
    input  logic              match_all_i,
    output logic              hit_o,
    output logic              gc_o,
    output logic              tenbit_o
);
    logic [ADDR_W-1:0] own_eq;
    logic [ADDR_W-1:0] alt_eq;
    logic [ADDR_W-1:0] masked_eq;
    logic              sec_hit;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign own_eq[i]    = ~(addr_i[i] ^ own_i[i]);
        assign alt_eq[i]    = ~(addr_i[i] ^ alt_i[i]);
        assign masked_eq[i] = own_eq[i] | alt_i[i];
    end

    // The 10-bit prefix is 1111_0 in the top five address bits
    if (ADDR_W >= 5) begin : g_tenbit
        localparam int PFX_W = 5;
        localparam logic [PFX_W-1:0] TEN_PFX = 5'b11110;
        assign tenbit_o = (addr_i[ADDR_W-1 -: PFX_W] == TEN_PFX);
    end else begin : g_no_tenbit
        assign tenbit_o = 1'b0;
    end

    assign sec_hit = alt_is_mask_i ? (&masked_eq) : (&alt_eq);
    assign gc_o    = gc_en_i & (addr_i == '0);
    assign hit_o   = match_all_i | (&own_eq) | sec_hit | gc_o | tenbit_o;
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2cam_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic [ADDR_W-1:0] alt_addr_i,
    input  logic              alt_is_mask_i,
    input  logic              gc_en_i,
    input  logic              match_all_i,
    output logic              match_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              rw_o,
    output logic              gc_o,
    output logic              tenbit_o,
    output logic              ack_o,
    output logic              wake_o
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(ADDR_W);

    am_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] shift_q;
    logic [BYTE_W-1:0] byte_q;
    logic              fall_seen_q;

    logic scl_rise, scl_fall, start_det, stop_det;
    logic hit;

    i2cam_line_watch u_watch (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2cam_compare #(.ADDR_W(ADDR_W)) u_cmp (
        .addr_i        (byte_q[BYTE_W-1:1]),
        .own_i         (own_addr_i),
        .alt_i         (alt_addr_i),
        .alt_is_mask_i (alt_is_mask_i),
        .gc_en_i       (gc_en_i),
        .match_all_i   (match_all_i),
        .hit_o         (hit),
        .gc_o          (gc_o),
        .tenbit_o      (tenbit_o)
    );

    // Next-state logic: START and STOP override every state
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_SHIFT;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_SHIFT:  if (scl_rise && cnt_q == LAST_BIT) state_d = ST_DECIDE;
                ST_DECIDE: state_d = hit ? ST_ACK : ST_SKIP;
                ST_ACK:    if (scl_fall && fall_seen_q) state_d = ST_PASS;
                ST_PASS:   state_d = ST_PASS;
                ST_SKIP:   state_d = ST_SKIP;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Bit capture and ninth-clock tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            shift_q     <= '0;
            byte_q      <= '0;
            fall_seen_q <= 1'b0;
        end else if (start_det) begin
            cnt_q   <= '0;
            shift_q <= '0;
        end else begin
            if (state_q == ST_SHIFT && scl_rise && !stop_det) begin
                shift_q <= {shift_q[ADDR_W-2:0], sda_i};
                cnt_q   <= cnt_q + 1'b1;
                if (cnt_q == LAST_BIT) byte_q <= {shift_q, sda_i};
            end
            if (state_q == ST_DECIDE)              fall_seen_q <= 1'b0;
            else if (state_q == ST_ACK && scl_fall) fall_seen_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        match_o = (state_q == ST_DECIDE) && hit;
        ack_o   = (state_q == ST_ACK);
        wake_o  = (state_q == ST_ACK) || (state_q == ST_PASS);
        addr_o  = byte_q[BYTE_W-1:1];
        rw_o    = byte_q[0];
    end
endmodule

// File: rtl/i2cam_checker.sv
module i2cam_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_i,
    input logic match_o,
    input logic ack_o,
    input logic wake_o
);
    p_match_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> !match_o);

    p_match_after_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> $past(scl_i));

    p_ack_follows_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> ack_o);

    p_ack_needs_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(match_o));

    p_wake_needs_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_o) |-> $past(match_o));

    p_stop_releases_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> (!ack_o && !wake_o));
endmodule

bind i2c_addr_match i2cam_checker u_chk (.*);

// File: tb/test_i2c_addr_match.sv
`timescale 1ns/1ps
module test_i2c_addr_match;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic [6:0] own = 7'h2A;
    logic [6:0] alt = 7'h55;
    logic       is_mask = 1'b0;
    logic       gc_en = 1'b1;
    logic       mall = 1'b0;
    logic       match_o, rw_o, gc_o, tenbit_o, ack_o, wake_o;
    logic [6:0] addr_o;

    int checks = 0;
    int errors = 0;
    int mcount = 0;
    bit done = 0;

    always #2 clk = ~clk;

    i2c_addr_match i_i2c_addr_match (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .own_addr_i(own), .alt_addr_i(alt), .alt_is_mask_i(is_mask),
        .gc_en_i(gc_en), .match_all_i(mall),
        .match_o(match_o), .addr_o(addr_o), .rw_o(rw_o), .gc_o(gc_o),
        .tenbit_o(tenbit_o), .ack_o(ack_o), .wake_o(wake_o)
    );

    always @(negedge clk) if (match_o) mcount++;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit exp_hit(input logic [6:0] a);
        bit sec;
        sec = is_mask ? ((a | alt) == (own | alt)) : (a == alt);
        return mall || (a == own) || sec || (gc_en && a == 0) || (a >= 7'h78 && a <= 7'h7B);
    endfunction

    function automatic string tag_of(input logic [6:0] a);
        if (mall) return "R7";
        if (a >= 7'h78 && a <= 7'h7B) return "R8";
        if (a == 0) return "R6";
        if (a == own) return "R2";
        if (is_mask && ((a | alt) == (own | alt))) return "R5";
        if (!is_mask && a == alt) return "R4";
        return "R3";
    endfunction

    task automatic bus_start();
        sda = 1'b1; wt(4); scl = 1'b1; wt(4); sda = 1'b0; wt(4); scl = 1'b0; wt(4);
    endtask

    task automatic bus_stop();
        sda = 1'b0; wt(4); scl = 1'b1; wt(4); sda = 1'b1; wt(4);
    endtask

    task automatic put_bit(input logic b);
        sda = b; wt(2); scl = 1'b1; wt(4); scl = 1'b0; wt(2);
    endtask

    // Eight bits plus the ninth clock, with the expected hit and wake level
    task automatic byte_phase(input logic [7:0] byt, input bit hit, input bit wake_after, input string tag);
        int base;
        base = mcount;
        for (int i = 7; i >= 1; i--) put_bit(byt[i]);
        sda = byt[0]; wt(2); scl = 1'b1;
        wt(1);
        chk({tag, "/R9"}, "match at first clock after 8th rise", int'(match_o), int'(hit));
        wt(3); scl = 1'b0; wt(2);
        chk({tag, "/R9"}, "match pulse cycles", mcount - base, int'(hit));
        if (hit) begin
            chk({tag, "/R2"}, "addr_o", int'(addr_o), int'(byt[7:1]));
            chk({tag, "/R2"}, "rw_o", int'(rw_o), int'(byt[0]));
            chk({tag, "/R6"}, "gc_o", int'(gc_o), int'(gc_en && byt[7:1] == 0));
            chk({tag, "/R8"}, "tenbit_o", int'(tenbit_o), int'(byt[7:3] == 5'b11110));
        end
        sda = 1'b1; wt(2); scl = 1'b1; wt(2);
        chk({tag, "/R10"}, "ack during ninth clock", int'(ack_o), int'(hit));
        wt(2); scl = 1'b0; wt(1);
        chk({tag, "/R10"}, "ack after ninth clock", int'(ack_o), 0);
        chk({tag, "/R11"}, "wake after byte", int'(wake_o), int'(wake_after));
        wt(1);
    endtask

    task automatic sweep_all(input int step);
        for (int a = 0; a < 128; a += step) begin
            logic [6:0] ad;
            bit h;
            ad = 7'(a);
            h = exp_hit(ad);
            bus_start();
            byte_phase({ad, ad[0]}, h, h, tag_of(ad));
            bus_stop();
            chk("R11", "wake after STOP", int'(wake_o), 0);
        end
    endtask

    initial begin
        wt(3);
        chk("R1", "match in reset", int'(match_o), 0);
        chk("R1", "ack in reset", int'(ack_o), 0);
        rst_n = 1'b1;
        wt(2);
        chk("R1", "wake after reset", int'(wake_o), 0);
        chk("R1", "addr_o after reset", int'(addr_o), 0);
        chk("R1", "rw_o after reset", int'(rw_o), 0);

        // Dual-address configuration with general call
        own = 7'h2A; alt = 7'h55; is_mask = 1'b0; gc_en = 1'b1; mall = 1'b0;
        sweep_all(1);

        // Mask configuration: range 0x40..0x4F, no general call
        own = 7'h40; alt = 7'h0F; is_mask = 1'b1; gc_en = 1'b0;
        sweep_all(1);

        // Match-everything mode
        own = 7'h2A; alt = 7'h55; is_mask = 1'b0; mall = 1'b1;
        sweep_all(9);
        mall = 1'b0; gc_en = 1'b1;

        // R3: a missed address ignores a following byte equal to own address
        bus_start();
        byte_phase(8'h22, 1'b0, 1'b0, "R3");
        byte_phase(8'h54, 1'b0, 1'b0, "R3");
        // the next START is still honoured
        bus_start();
        byte_phase(8'h55, 1'b1, 1'b1, "R3");
        // R3: a data byte after a matched address gives no new match
        byte_phase(8'h54, 1'b0, 1'b1, "R3");
        bus_stop();
        chk("R11", "wake after STOP", int'(wake_o), 0);

        // R12: repeated START mid-byte restarts capture
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_start();
        byte_phase(8'h54, 1'b1, 1'b1, "R12");
        // R11: a repeated START drops the wake request
        bus_start();
        chk("R11", "wake after repeated START", int'(wake_o), 0);
        // R12: STOP mid-byte abandons capture; bits without START are ignored
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_stop();
        scl = 1'b0; wt(4);
        byte_phase(8'h54, 1'b0, 1'b0, "R12");
        scl = 1'b1; wt(4);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule